// File: doc/BRIEF.md
# Gated Ratio Clock Divider

This block turns a fast source clock into a slower, periodic enable of programmable length. The period and the length of its high part come from two separate fields, and a mode bit says how the period field is read. In zero-based mode a nonzero period field `v` gives a period of `v+1` source cycles. In one-based mode it gives `v` source cycles. A period field of zero stops the divider completely. Next to the divided level the block gives a one-cycle strobe that marks the first source cycle of every output period.

A write presents a new period value, high value and mode together, and the block keeps them as pending settings. The running period always finishes with the settings it began with. The pending settings take effect only when that period ends, so a reprogramming never produces a shortened or stretched pulse. While the divider is stopped, pending settings are picked up on the next source clock edge.

Top module: `gated_ratio_divider`

## Requirements
- R1: After reset the divider is stopped: `divClk` and `periodTick` are 0 and stay 0 until a nonzero period field has been written.
- R2: A period field of 0 stops the output. Once it is in force, `divClk` and `periodTick` stay 0 for as long as it remains. A period that is already running when the zero is written still completes first.
- R3: With `cfgOneBased` = 0, a nonzero period field `v` gives an output period of `v+1` source cycles.
- R4: With `cfgOneBased` = 1, a nonzero period field `v` gives an output period of `v` source cycles. With `v` = 1, `divClk` and `periodTick` are 1 on every cycle.
- R5: `divClk` is high from the first cycle of each period. It stays high for `h+1` cycles in zero-based mode and `h` cycles in one-based mode, where `h` is the high field, and is low for the rest of the period. A one-based high field of 0 keeps `divClk` low for the whole period.
- R6: If the high length is at least the period (period of 2 or more), `divClk` is high for period-1 cycles and low in the last cycle.
- R7: A write taken on clock edge E while a period is running leaves that period unchanged. The new settings start with the next period. If the divider is stopped at E, the first period of the new settings begins with the cycle after edge E+1.
- R8: `periodTick` is 1 in exactly the first source cycle of every output period and 0 otherwise.
- R9: The all-ones period field gives the longest period: 2^DIV_W cycles in zero-based mode and 2^DIV_W-1 cycles in one-based mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe; captures the three setting inputs as pending settings |
| cfgPeriod | input | DIV_W | Period field (0 = stopped) |
| cfgHigh | input | DIV_W | High-length field |
| cfgOneBased | input | 1 | 0 = zero-based period and high fields, 1 = one-based |
| divClk | output | 1 | Divided clock level / enable |
| periodTick | output | 1 | Strobe on the first cycle of each output period |

## Verification
Both outputs are decoded from registers. Each therefore changes one clock edge after the counter or the active settings change, and the bench samples them on the falling edge, half a cycle later. A write sampled on edge E reaches the pending settings at E. The active settings change at E+1 when the divider is stopped, or at the edge that ends the running period. The bench therefore expects a restart strobe on the second falling edge after it raises the write strobe. For a write made in the middle of a period, it checks every remaining cycle against the old settings before it checks the new period. Each period check begins on a sampled strobe and walks the period one falling edge at a time, so each expected level belongs to a known counter position.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

  // How the period and high fields are interpreted
  typedef enum logic {
    BASE_ZERO = 1'b0,   // field v means v+1 cycles
    BASE_ONE  = 1'b1    // field v means v cycles
  } divBase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;    // a nonzero period is in force
    logic wrap;   // counter returns to the first cycle of a period
  } divStrobe_t;

endpackage

// File: rtl/gdiv_ctrl.sv
module gdiv_ctrl
  import gdiv_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [DIV_W-1:0]   cfgPeriod,
  input  logic [DIV_W-1:0]   cfgHigh,
  input  logic               cfgOneBased,
  input  logic               lastCycle,
  output divStrobe_t         strobe,
  output logic [DIV_W:0]     periodLen,
  output logic [DIV_W:0]     highLen,
  output logic               running,
  output logic               boundary,
  output logic               pendZero,
  output logic [2*DIV_W:0]   activeWord
);

  localparam int LEN_W = DIV_W + 1;

  logic [DIV_W-1:0] pendPeriod, pendHigh;
  divBase_e         pendBase;
  logic [DIV_W-1:0] actPeriod, actHigh;
  divBase_e         actBase;
  logic [LEN_W-1:0] rawHigh;

  // Pending settings: overwritten by every write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPeriod <= '0;
      pendHigh   <= '0;
      pendBase   <= BASE_ZERO;
    end else if (cfgWrEn) begin
      pendPeriod <= cfgPeriod;
      pendHigh   <= cfgHigh;
      pendBase   <= divBase_e'(cfgOneBased);
    end
  end

  // Active settings: replaced only at a period boundary or while stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPeriod <= '0;
      actHigh   <= '0;
      actBase   <= BASE_ZERO;
    end else if (boundary) begin
      actPeriod <= pendPeriod;
      actHigh   <= pendHigh;
      actBase   <= pendBase;
    end
  end

  always_comb begin
    running  = (actPeriod != '0);
    boundary = !running || lastCycle;

    if (actBase == BASE_ONE) begin
      periodLen = {1'b0, actPeriod};
      rawHigh   = {1'b0, actHigh};
    end else begin
      periodLen = {1'b0, actPeriod} + LEN_W'(1);
      rawHigh   = {1'b0, actHigh} + LEN_W'(1);
    end

    // A one-cycle period is a continuous enable; otherwise keep one low cycle
    if (periodLen == LEN_W'(1))
      highLen = LEN_W'(1);
    else if (rawHigh >= periodLen)
      highLen = periodLen - LEN_W'(1);
    else
      highLen = rawHigh;

    strobe.run  = running;
    strobe.wrap = boundary;
  end

  assign pendZero   = (pendPeriod == '0);
  assign activeWord = {actBase, actHigh, actPeriod};

endmodule

// File: rtl/gdiv_datapath.sv
module gdiv_datapath
  import gdiv_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [DIV_W:0]     periodLen,
  input  logic [DIV_W:0]     highLen,
  output logic [DIV_W-1:0]   cnt,
  output logic               lastCycle,
  output logic               divClk,
  output logic               periodTick
);

  localparam int LEN_W = DIV_W + 1;

  logic [LEN_W-1:0] cntWide;

  // Position inside the current period; held at 0 while stopped
  always_ff @(posedge clk) begin
    if (!rstN)
      cnt <= '0;
    else if (strobe.wrap)
      cnt <= '0;
    else
      cnt <= cnt + DIV_W'(1);
  end

  always_comb begin
    cntWide    = {1'b0, cnt};
    lastCycle  = strobe.run && (cntWide == periodLen - LEN_W'(1));
    divClk     = strobe.run && (cntWide < highLen);
    periodTick = strobe.run && (cnt == '0);
  end

endmodule

// File: rtl/gated_ratio_divider.sv
module gated_ratio_divider
  import gdiv_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [DIV_W-1:0] cfgPeriod,
  input  logic [DIV_W-1:0] cfgHigh,
  input  logic             cfgOneBased,
  output logic             divClk,
  output logic             periodTick
);

  divStrobe_t       strobe;
  logic [DIV_W:0]   periodLen, highLen;
  logic [DIV_W-1:0] cnt;
  logic             lastCycle, running, boundary, pendZero;
  logic [2*DIV_W:0] activeWord;

  gdiv_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgPeriod  (cfgPeriod),
    .cfgHigh    (cfgHigh),
    .cfgOneBased(cfgOneBased),
    .lastCycle  (lastCycle),
    .strobe     (strobe),
    .periodLen  (periodLen),
    .highLen    (highLen),
    .running    (running),
    .boundary   (boundary),
    .pendZero   (pendZero),
    .activeWord (activeWord)
  );

  gdiv_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .periodLen (periodLen),
    .highLen   (highLen),
    .cnt       (cnt),
    .lastCycle (lastCycle),
    .divClk    (divClk),
    .periodTick(periodTick)
  );

endmodule

// File: rtl/gdiv_checker.sv
module gdiv_checker #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             divClk,
  input logic             periodTick,
  input logic             running,
  input logic             boundary,
  input logic             lastCycle,
  input logic             pendZero,
  input logic [DIV_W:0]   periodLen,
  input logic [DIV_W-1:0] cnt,
  input logic [2*DIV_W:0] activeWord
);

  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!divClk && !periodTick));

  // R2: a zero period that is pending at a period end silences the next cycle
  p_gate_after_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lastCycle && pendZero) |=> (!divClk && !periodTick));

  // R3: counter never reaches the period length
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> ({1'b0, cnt} < periodLen));

  // R6: the last cycle of a period of two or more is low
  p_last_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastCycle && periodLen > 1) |-> !divClk);

  // R7: active settings only move at a boundary
  p_hold_settings_r7: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(activeWord));

  // R8: a period start strobe follows a period end or a stopped cycle
  p_tick_follows_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    periodTick |-> ($past(lastCycle) || !$past(running)));

endmodule

bind gated_ratio_divider gdiv_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .divClk    (divClk),
  .periodTick(periodTick),
  .running   (running),
  .boundary  (boundary),
  .lastCycle (lastCycle),
  .pendZero  (pendZero),
  .periodLen (periodLen),
  .cnt       (cnt),
  .activeWord(activeWord)
);

// File: tb/tb_gated_ratio_divider.sv
module tb_gated_ratio_divider;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [DIV_W-1:0] cfgPeriod = '0;
  logic [DIV_W-1:0] cfgHigh = '0;
  logic             cfgOneBased = 1'b0;
  logic             divClk, periodTick;

  int checks = 0;
  int failures = 0;

  gated_ratio_divider #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgPeriod(cfgPeriod),
    .cfgHigh(cfgHigh), .cfgOneBased(cfgOneBased),
    .divClk(divClk), .periodTick(periodTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expectVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Write strobe raised at a falling edge; returns one falling edge later
  task automatic writeCfg(int per, int hi, bit one);
    cfgPeriod   = DIV_W'(per);
    cfgHigh     = DIV_W'(hi);
    cfgOneBased = one;
    cfgWrEn     = 1'b1;
    @(negedge clk);
    cfgWrEn     = 1'b0;
  endtask

  task automatic waitTick(string req);
    for (int i = 0; i < 300; i++) begin
      if (periodTick) return;
      @(negedge clk);
    end
    expectVal(req, "tick timeout", 0, 1);
  endtask

  // Called on the first cycle of a period; walks it and checks the restart
  task automatic checkPeriod(string req, int n, int h);
    for (int i = 0; i < n; i++) begin
      expectVal(req, "divClk", int'(divClk), (i < h) ? 1 : 0);
      expectVal(req, "periodTick", int'(periodTick), (i == 0) ? 1 : 0);
      @(negedge clk);
    end
    expectVal(req, "restart tick", int'(periodTick), 1);
  endtask

  // Ensure the new settings are in force: second tick is always theirs
  task automatic applyCfg(string req, int per, int hi, bit one);
    writeCfg(per, hi, one);
    waitTick(req);
    @(negedge clk);
    waitTick(req);
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) begin
      expectVal("R1", "divClk", int'(divClk), 0);
      expectVal("R1", "periodTick", int'(periodTick), 0);
      @(negedge clk);
    end
  endtask

  task automatic testStartFromStopped();
    writeCfg(3, 1, 1'b0);               // zero-based: 4-cycle period, 2 high
    expectVal("R7", "not yet started", int'(periodTick), 0);
    @(negedge clk);
    expectVal("R7", "start latency tick", int'(periodTick), 1);
    checkPeriod("R3", 4, 2);
    checkPeriod("R8", 4, 2);
  endtask

  task automatic testOneBased();
    applyCfg("R4", 5, 2, 1'b1);
    checkPeriod("R4", 5, 2);
    applyCfg("R5", 3, 0, 1'b1);         // one-based high 0: always low
    checkPeriod("R5", 3, 0);
    applyCfg("R5", 6, 0, 1'b0);         // zero-based high 0: one cycle high
    checkPeriod("R5", 7, 1);
  endtask

  task automatic testClamp();
    applyCfg("R6", 2, 7, 1'b0);         // period 3, high request 8
    checkPeriod("R6", 3, 2);
    applyCfg("R6", 4, 9, 1'b1);         // period 4, high request 9
    checkPeriod("R6", 4, 3);
  endtask

  task automatic testContinuous();
    applyCfg("R4", 1, 0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      expectVal("R4", "continuous divClk", int'(divClk), 1);
      expectVal("R4", "continuous tick", int'(periodTick), 1);
      @(negedge clk);
    end
  endtask

  task automatic measure(string req, int expLen);
    int n = 0;
    waitTick(req);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (periodTick) break;
    end
    expectVal(req, "period length", n, expLen);
  endtask

  task automatic testExtremes();
    applyCfg("R9", 63, 5, 1'b0);
    measure("R9", 64);
    applyCfg("R9", 63, 5, 1'b1);
    measure("R9", 63);
  endtask

  task automatic testMidUpdate();
    applyCfg("R7", 3, 1, 1'b0);         // pattern 1100
    writeCfg(1, 0, 1'b0);               // new: period 2, one high
    expectVal("R7", "old cycle1", int'(divClk), 1);
    @(negedge clk);
    expectVal("R7", "old cycle2", int'(divClk), 0);
    expectVal("R7", "old cycle2 tick", int'(periodTick), 0);
    @(negedge clk);
    expectVal("R7", "old cycle3", int'(divClk), 0);
    @(negedge clk);
    expectVal("R7", "new period tick", int'(periodTick), 1);
    checkPeriod("R7", 2, 1);
  endtask

  task automatic testGate();
    applyCfg("R2", 3, 1, 1'b0);
    writeCfg(0, 3, 1'b0);
    expectVal("R2", "running period completes", int'(divClk), 1);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      expectVal("R2", "gated divClk", int'(divClk), 0);
      expectVal("R2", "gated tick", int'(periodTick), 0);
      @(negedge clk);
    end
    writeCfg(2, 0, 1'b1);               // one-based period 2, high 0
    @(negedge clk);
    expectVal("R7", "restart after gate", int'(periodTick), 1);
    checkPeriod("R5", 2, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    expectVal("WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStartFromStopped();
    testOneBased();
    testClamp();
    testContinuous();
    testExtremes();
    testMidUpdate();
    testGate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule